// File: doc/BRIEF.md
# DMA Bus Arbitration Handshake Sequencer

This block controls how a four-channel DMA controller acquires a shared system bus from the processor, runs transfer cycles on it, and hands it back. A peripheral raises its channel request. The sequencer then raises a hold request and waits, for as many cycles as needed, until the processor grants the bus through a hold-acknowledge. Once it owns the bus, the sequencer enables the address drivers and produces active-low memory and I/O strobes for one transfer at a time. It acknowledges the serviced channel while its strobes are active.

Each transfer produces a one-cycle step pulse with the channel index. A separate address/count engine uses that pulse to advance, and it answers with a last-transfer flag. Each channel is set to either single or burst service. A single-mode channel moves one byte per grant and then goes back to arbitration. A burst-mode channel keeps the bus until its block ends or an abort arrives. The bus is kept while any unmasked request remains. When none remains, the drivers are released first and the hold request is dropped one cycle later.

Top module: `dma_bus_seq`

## Requirements
- R1: From idle, `hold_req_o` rises one cycle after any channel has `chan_req_i` high and `mask_i` low. A request on a masked channel leaves `hold_req_o` low.
- R2: `addr_en_o`, `bus_oe_o`, `chan_ack_o` and all strobes stay inactive until `hold_ack_i` has been seen high. The wait for it has no limit.
- R3: A transfer runs in three phases, one after another.
  - Setup: address enabled, strobes high, acknowledge low.
  - Active: strobes low and one-hot `chan_ack_o` for the channel.
  - End: strobes high, acknowledge low and `step_o` high for one cycle.
  - Direction bit `dir_i[c]`=1 drives `ior_no` and `memw_no` low (peripheral to memory). `dir_i[c]`=0 drives `memr_no` and `iow_no` low.
- R4: While `ready_i` is low in the active phase, that phase is held with strobes and acknowledge unchanged.
- R5: Among simultaneous unmasked requests the lowest channel index wins, and `step_ch_o` gives the serviced index in binary.
- R6: At the end phase, if `hold_ack_i` is high and an unmasked request is pending, the next setup phase follows at once and `hold_req_o` stays high.
- R7: When no request is pending at the end phase, one cycle has `hold_req_o` high with `addr_en_o` and `bus_oe_o` low. `hold_req_o` falls on the following cycle.
- R8: A channel with `burst_i[c]`=0 moves one byte per grant. A higher-priority request that arrives during that byte is serviced next.
- R9: A channel with `burst_i[c]`=1 keeps the bus, whatever the request lines do, until an end phase with `xfer_last_i` high.
- R10: `abort_ni` low during any phase of a burst transfer makes that transfer the last one of the burst.
- R11: `tc_no` is low exactly in an end phase where `xfer_last_i` is high.
- R12: If `hold_ack_i` falls during a transfer, the transfer completes through its end phase, and the release sequence of R7 then follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_req_i | input | NUM_CH | Per-channel service request |
| mask_i | input | NUM_CH | Per-channel mask, 1 = ignore request |
| burst_i | input | NUM_CH | Per-channel mode, 1 = burst, 0 = single |
| dir_i | input | NUM_CH | Per-channel direction, 1 = peripheral to memory |
| hold_ack_i | input | 1 | Processor grants the bus |
| ready_i | input | 1 | Low stretches the strobe-active phase |
| xfer_last_i | input | 1 | Count engine flags the final transfer of the block |
| abort_ni | input | 1 | External abort of the current burst, active low |
| hold_req_o | output | 1 | Bus request to the processor |
| chan_ack_o | output | NUM_CH | Per-channel acknowledge, one-hot |
| addr_en_o | output | 1 | Address driver enable |
| bus_oe_o | output | 1 | Strobe output enable; low means tri-stated |
| memr_no | output | 1 | Memory read strobe, active low |
| memw_no | output | 1 | Memory write strobe, active low |
| ior_no | output | 1 | I/O read strobe, active low |
| iow_no | output | 1 | I/O write strobe, active low |
| step_o | output | 1 | One-cycle pulse per completed transfer |
| step_ch_o | output | CH_W | Index of the serviced channel |
| tc_no | output | 1 | Final-transfer marker, active low |

## Verification
The checks that run on every cycle cover these rules: the acknowledge is never held by more than one channel, the bus is driven only after a grant, and the drivers are released before the hold request falls. They also check that the step pulse lasts one cycle, that the final-transfer marker appears only on a step, and that a low ready freezes the active phase. Some behaviour can only be shown in the bench scenarios. These include the exact phase-by-phase strobe pattern for each direction, fixed priority between channels, and preemption at single-byte boundaries. They also include a burst running to the count engine's last flag, a burst cut short by an abort, and the completion of a transfer after the grant is withdrawn.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_ADDR,
    ST_XFER,
    ST_END,
    ST_REL
  } seq_state_e;
endpackage

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] elig_i,
  output logic              any_o,
  output logic [CH_W-1:0]   win_o
);
  // lowest index wins
  always_comb begin
    win_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (elig_i[i]) win_o = CH_W'(i);
    end
  end
  assign any_o = |elig_i;
endmodule

// File: rtl/dma_ack_dec.sv
module dma_ack_dec #(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              en_i,
  input  logic [CH_W-1:0]   ch_i,
  output logic [NUM_CH-1:0] ack_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ack
    assign ack_o[g] = en_i && (ch_i == CH_W'(g));
  end
endmodule

// File: rtl/dma_strobe_gen.sv
module dma_strobe_gen (
  input  logic active_i,
  input  logic dir_i,
  output logic memr_no,
  output logic memw_no,
  output logic ior_no,
  output logic iow_no
);
  // dir 1: peripheral -> memory, dir 0: memory -> peripheral
  assign ior_no  = !(active_i && dir_i);
  assign memw_no = !(active_i && dir_i);
  assign memr_no = !(active_i && !dir_i);
  assign iow_no  = !(active_i && !dir_i);
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              any_i,
  input  logic [CH_W-1:0]   win_i,
  input  logic [NUM_CH-1:0] burst_i,
  input  logic [NUM_CH-1:0] dir_i,
  input  logic              hold_ack_i,
  input  logic              ready_i,
  input  logic              xfer_last_i,
  input  logic              abort_ni,
  output seq_state_e        state_o,
  output logic [CH_W-1:0]   ch_o,
  output logic              dir_o
);
  seq_state_e      state_q, state_d;
  logic [CH_W-1:0] ch_q, ch_d;
  logic            burst_q, burst_d;
  logic            dir_q, dir_d;
  logic            abort_q, abort_d;
  logic            term;

  assign term = xfer_last_i || abort_q || !abort_ni;

  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    burst_d = burst_q;
    dir_d   = dir_q;
    abort_d = abort_q;
    unique case (state_q)
      ST_IDLE: if (any_i) state_d = ST_HOLD;
      ST_HOLD: begin
        if (hold_ack_i) begin
          if (any_i) begin
            state_d = ST_ADDR;
            ch_d    = win_i;
            burst_d = burst_i[win_i];
            dir_d   = dir_i[win_i];
            abort_d = 1'b0;
          end else begin
            state_d = ST_REL;
          end
        end
      end
      ST_ADDR: begin
        state_d = ST_XFER;
        if (!abort_ni) abort_d = 1'b1;
      end
      ST_XFER: begin
        if (!abort_ni) abort_d = 1'b1;
        if (ready_i) state_d = ST_END;
      end
      ST_END: begin
        if (!hold_ack_i) begin
          state_d = ST_REL;
        end else if (burst_q && !term) begin
          state_d = ST_ADDR;
          abort_d = 1'b0;
        end else if (any_i) begin
          state_d = ST_ADDR;
          ch_d    = win_i;
          burst_d = burst_i[win_i];
          dir_d   = dir_i[win_i];
          abort_d = 1'b0;
        end else begin
          state_d = ST_REL;
        end
      end
      ST_REL:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      burst_q <= 1'b0;
      dir_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      burst_q <= burst_d;
      dir_q   <= dir_d;
      abort_q <= abort_d;
    end
  end

  assign state_o = state_q;
  assign ch_o    = ch_q;
  assign dir_o   = dir_q;
endmodule

// File: rtl/dma_bus_seq.sv
module dma_bus_seq
  import dma_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] chan_req_i,
  input  logic [NUM_CH-1:0] mask_i,
  input  logic [NUM_CH-1:0] burst_i,
  input  logic [NUM_CH-1:0] dir_i,
  input  logic              hold_ack_i,
  input  logic              ready_i,
  input  logic              xfer_last_i,
  input  logic              abort_ni,
  output logic              hold_req_o,
  output logic [NUM_CH-1:0] chan_ack_o,
  output logic              addr_en_o,
  output logic              bus_oe_o,
  output logic              memr_no,
  output logic              memw_no,
  output logic              ior_no,
  output logic              iow_no,
  output logic              step_o,
  output logic [CH_W-1:0]   step_ch_o,
  output logic              tc_no
);
  seq_state_e      state;
  logic [CH_W-1:0] win, cur_ch;
  logic            any_req, cur_dir, in_xfer, own_bus;

  dma_prio_arb #(.NUM_CH(NUM_CH)) i_arb (
    .elig_i (chan_req_i & ~mask_i),
    .any_o  (any_req),
    .win_o  (win)
  );

  dma_seq_fsm #(.NUM_CH(NUM_CH)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .any_i       (any_req),
    .win_i       (win),
    .burst_i     (burst_i),
    .dir_i       (dir_i),
    .hold_ack_i  (hold_ack_i),
    .ready_i     (ready_i),
    .xfer_last_i (xfer_last_i),
    .abort_ni    (abort_ni),
    .state_o     (state),
    .ch_o        (cur_ch),
    .dir_o       (cur_dir)
  );

  assign in_xfer = (state == ST_XFER);
  assign own_bus = (state == ST_ADDR) || in_xfer || (state == ST_END);

  dma_ack_dec #(.NUM_CH(NUM_CH)) i_ack (
    .en_i  (in_xfer),
    .ch_i  (cur_ch),
    .ack_o (chan_ack_o)
  );

  dma_strobe_gen i_strb (
    .active_i (in_xfer),
    .dir_i    (cur_dir),
    .memr_no  (memr_no),
    .memw_no  (memw_no),
    .ior_no   (ior_no),
    .iow_no   (iow_no)
  );

  assign hold_req_o = (state != ST_IDLE);
  assign addr_en_o  = own_bus;
  assign bus_oe_o   = own_bus;
  assign step_o     = (state == ST_END);
  assign step_ch_o  = cur_ch;
  assign tc_no      = !((state == ST_END) && xfer_last_i);
endmodule

// File: rtl/dma_bus_seq_chk.sv
module dma_bus_seq_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] chan_req_i,
  input logic [NUM_CH-1:0] mask_i,
  input logic              hold_ack_i,
  input logic              ready_i,
  input logic              hold_req_o,
  input logic [NUM_CH-1:0] chan_ack_o,
  input logic              addr_en_o,
  input logic              bus_oe_o,
  input logic              memr_no,
  input logic              memw_no,
  input logic              step_o,
  input logic              tc_no
);
  p_hold_needs_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_req_o) |-> $past(|(chan_req_i & ~mask_i)));

  p_drive_after_grant_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_en_o) |-> $past(hold_ack_i));

  p_ack_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(chan_ack_o));

  p_ack_in_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|chan_ack_o) |-> (bus_oe_o && addr_en_o && (!memr_no || !memw_no)));

  p_step_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o);

  p_ready_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|chan_ack_o) && !ready_i) |=> (chan_ack_o == $past(chan_ack_o)));

  p_release_order_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_req_o) |-> !$past(bus_oe_o));

  p_tc_on_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tc_no |-> step_o);

  p_grant_lost_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && !hold_ack_i) |=> (hold_req_o && !bus_oe_o));
endmodule

bind dma_bus_seq dma_bus_seq_chk #(.NUM_CH(NUM_CH)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .chan_req_i (chan_req_i),
  .mask_i     (mask_i),
  .hold_ack_i (hold_ack_i),
  .ready_i    (ready_i),
  .hold_req_o (hold_req_o),
  .chan_ack_o (chan_ack_o),
  .addr_en_o  (addr_en_o),
  .bus_oe_o   (bus_oe_o),
  .memr_no    (memr_no),
  .memw_no    (memw_no),
  .step_o     (step_o),
  .tc_no      (tc_no)
);

// File: tb/test_dma_bus_seq.sv
`timescale 1ns/1ps
module test_dma_bus_seq;
  localparam int NUM_CH = 4;
  localparam int CH_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] req = '0, mask = '0, burst = '0, dir = '0;
  logic hlda = 1'b0, ready = 1'b1, last = 1'b0, abort_n = 1'b1;
  logic hold, aen, oe, memr_n, memw_n, ior_n, iow_n, step, tc_n;
  logic [3:0] ack;
  logic [CH_W-1:0] step_ch;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_bus_seq #(.NUM_CH(NUM_CH)) i_dma_bus_seq (
    .clk_i(clk), .rst_ni(rst_n), .chan_req_i(req), .mask_i(mask),
    .burst_i(burst), .dir_i(dir), .hold_ack_i(hlda), .ready_i(ready),
    .xfer_last_i(last), .abort_ni(abort_n), .hold_req_o(hold),
    .chan_ack_o(ack), .addr_en_o(aen), .bus_oe_o(oe), .memr_no(memr_n),
    .memw_no(memw_n), .ior_no(ior_n), .iow_no(iow_n), .step_o(step),
    .step_ch_o(step_ch), .tc_no(tc_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 30; i++) begin
      if (!hold) break;
      tick();
    end
  endtask

  // {req, hlda, ready | hold, aen, ack, strobes{memr,memw,ior,iow}, step, ch}
  // dir = 0010 fixed: ch1 peripheral->memory, others memory->peripheral
  localparam int NV = 17;
  localparam logic [18:0] VEC [NV] = '{
    {4'b0010, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0000, 4'b1111, 1'b0, 2'd0}, // R1 hold
    {4'b0010, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0000, 4'b1111, 1'b0, 2'd0}, // R2 wait
    {4'b0010, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0000, 4'b1111, 1'b0, 2'd0}, // R3 setup
    {4'b0010, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0010, 4'b1001, 1'b0, 2'd0}, // R3 active dir1
    {4'b0000, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0000, 4'b1111, 1'b1, 2'd1}, // R3 end
    {4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 4'b0000, 4'b1111, 1'b0, 2'd0}, // R7 release
    {4'b0000, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0000, 4'b1111, 1'b0, 2'd0}, // R7 hold drop
    {4'b0101, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0000, 4'b1111, 1'b0, 2'd0},
    {4'b0101, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0000, 4'b1111, 1'b0, 2'd0},
    {4'b0101, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0001, 4'b0110, 1'b0, 2'd0}, // R5 ch0 wins
    {4'b0101, 1'b1, 1'b0, 1'b1, 1'b1, 4'b0001, 4'b0110, 1'b0, 2'd0}, // R4 stretch
    {4'b0101, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0000, 4'b1111, 1'b1, 2'd0},
    {4'b0100, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0000, 4'b1111, 1'b0, 2'd0}, // R6 no drop
    {4'b0100, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0100, 4'b0110, 1'b0, 2'd0},
    {4'b0000, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0000, 4'b1111, 1'b1, 2'd2},
    {4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 4'b0000, 4'b1111, 1'b0, 2'd0},
    {4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0000, 4'b1111, 1'b0, 2'd0}
  };

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int steps;
    int second_ch;
    bit seen, held_ok;
    // reset state
    repeat (3) @(posedge clk);
    #1;
    chk(!hold && !aen && !oe && ack == 0 && {memr_n, memw_n, ior_n, iow_n} == 4'hF && tc_n,
        "reset R1 R2", {hold, aen, oe, ack}, 0);
    @(negedge clk) rst_n = 1'b1;

    // table walk: R3 R4 R5 R6 R7
    dir = 4'b0010;
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {req, hlda, ready} = VEC[v][18:13];
      tick();
      chk({hold, aen, oe, ack, memr_n, memw_n, ior_n, iow_n, step} ==
          {VEC[v][12:11], VEC[v][11], VEC[v][10:2]} &&
          (!VEC[v][2] || step_ch == VEC[v][1:0]) && tc_n,
          $sformatf("vec%0d R3 R4 R5 R6 R7", v),
          {hold, aen, oe, ack, memr_n, memw_n, ior_n, iow_n, step, step_ch},
          {VEC[v][12:11], VEC[v][11], VEC[v][10:0]});
    end
    ready = 1'b1;

    // R1: masked request ignored, then unmasked raises hold after one edge
    @(negedge clk);
    mask = 4'b0010; req = 4'b0010; hlda = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 6; i++) begin tick(); if (hold) seen = 1'b1; end
    chk(!seen, "masked R1", seen, 0);
    mask = 4'b0000;
    tick();
    chk(hold, "unmask R1", hold, 1);

    // R2: arbitrary wait for grant
    held_ok = 1'b1;
    for (int i = 0; i < 25; i++) begin
      tick();
      if (aen || oe || ack != 0 || !hold) held_ok = 1'b0;
    end
    chk(held_ok, "long wait R2", held_ok, 1);
    req = 4'b0000; hlda = 1'b1;
    wait_idle();
    chk(!hold && !oe, "grant without request R7", hold, 0);

    // R9 R11: burst on ch3 to last flag, request dropped after grant
    burst = 4'b1000; dir = 4'b0000; req = 4'b1000; hlda = 1'b1;
    steps = 0; seen = 1'b0;
    for (int i = 0; i < 60; i++) begin
      tick();
      if (aen) req = 4'b0000;
      if (hold) seen = 1'b1;
      if (seen && !hold) break;
      if (step) begin
        last = (steps == 2);
        #1;
        chk(step_ch == 2'd3, "burst ch R9", step_ch, 3);
        chk(tc_n == !(steps == 2), "tc marker R11", tc_n, !(steps == 2));
        steps++;
      end else begin
        last = 1'b0;
      end
    end
    last = 1'b0;
    chk(steps == 3, "burst length R9", steps, 3);

    // R10: abort during second burst transfer
    req = 4'b1000; steps = 0; seen = 1'b0;
    for (int i = 0; i < 60; i++) begin
      tick();
      abort_n = 1'b1;
      if (aen) req = 4'b0000;
      if (hold) seen = 1'b1;
      if (seen && !hold) break;
      if (step) steps++;
      else if (steps == 1 && aen && ack == 0) abort_n = 1'b0;
    end
    abort_n = 1'b1;
    chk(steps == 2, "abort burst R10", steps, 2);

    // R8 R5: single ch2 preempted by ch0 at byte boundary
    burst = 4'b0000; req = 4'b0100; steps = 0; second_ch = -1;
    for (int i = 0; i < 60; i++) begin
      tick();
      if (step) begin
        steps++;
        if (steps == 1) req = 4'b0101;
        if (steps == 2) begin second_ch = step_ch; req = 4'b0000; end
      end
      if (steps >= 2 && !hold) break;
    end
    chk(second_ch == 0, "single preempt R8 R5", second_ch, 0);
    wait_idle();

    // R12: grant withdrawn in setup phase
    req = 4'b0010; dir = 4'b0010; hlda = 1'b1;
    for (int i = 0; i < 20; i++) begin tick(); if (aen) break; end
    hlda = 1'b0;
    tick();
    chk(ack == 4'b0010 && !ior_n && !memw_n, "finish active R12", ack, 2);
    req = 4'b0000;
    tick();
    chk(step && step_ch == 2'd1, "finish end R12", step, 1);
    tick();
    chk(hold && !oe && !aen, "release R12", {hold, oe}, 2);
    tick();
    chk(!hold, "hold drop R12", hold, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule